// File: doc/BRIEF.md
# Interrupt Halt and Request Logic for a SCSI Controller

This block collects one-cycle event pulses from two interrupt source groups: a DMA group and a SCSI group. It holds each event in a sticky status bit until software clears it with a write-one-to-clear acknowledge. For every pending bit it decides whether the script execution engine must halt.

Every DMA event is fatal. A SCSI event is fatal unless it belongs to the nonfatal set of the current operating mode. A nonfatal event becomes fatal when its enable bit is set. Any fatal pending bit raises a halt request and drives a registered, active-low interrupt request pin. A mask control bit can hide that pin without dropping the interrupt. Two summary flags report whether anything is pending in each group, so that software can poll.

Top module: `irq_halt_ctrl`

## Requirements
- R1: A status bit is set by a one-cycle event pulse and is visible on `dma_stat`/`scsi_stat` after the next clock edge. It stays set until an acknowledge with a 1 in that position arrives. If an event and an acknowledge for the same bit arrive in the same cycle, the bit stays set.
- R2: Any set `dma_stat` bit raises `halt_req` in the same cycle that it is visible, and it drives the pin, regardless of any enable.
- R3: In initiator mode (`target_mode`=0), SCSI bits 0 (function complete), 1 (selected), 2 (reselected), 4 (general timer expired) and 5 (handshake timer expired) are nonfatal. When one of these is pending and not enabled, its status bit still latches, but it raises neither `halt_req` nor the pin.
- R4: In target mode (`target_mode`=1), SCSI bit 3 (attention active) is also nonfatal. In initiator mode, bit 3 is fatal.
- R5: SCSI bits 6 and above are fatal in both modes.
- R6: A nonfatal SCSI bit whose `scsi_en` bit is 1 is treated as fatal: it raises `halt_req` and drives the pin.
- R7: While `pin_mask`=1, `irq_n` stays high, and the pending status bits and `halt_req` are kept.
- R8: When `pin_mask` is cleared while a fatal bit is pending, `irq_n` goes low one clock edge later, with no new event.
- R9: `dma_pend` is the OR of `dma_stat`, and `scsi_pend` is the OR of `scsi_stat`. Both include nonfatal, unenabled bits.
- R10: `irq_n` is registered. It goes low one edge after `halt_req` rises (when unmasked), and it returns high one edge after the last fatal pending bit is cleared.
- R11: After reset, all status bits, `halt_req` and both summary flags are 0, and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_evt | input | DMA_W | DMA event pulses |
| scsi_evt | input | SCSI_W | SCSI event pulses |
| target_mode | input | 1 | 1 = target mode, 0 = initiator mode |
| scsi_en | input | SCSI_W | Per-bit SCSI interrupt enables |
| pin_mask | input | 1 | 1 = hold the request pin inactive |
| dma_ack | input | DMA_W | Write-one-to-clear for DMA status |
| scsi_ack | input | SCSI_W | Write-one-to-clear for SCSI status |
| dma_stat | output | DMA_W | Latched DMA status |
| scsi_stat | output | SCSI_W | Latched SCSI status |
| dma_pend | output | 1 | Any DMA status pending |
| scsi_pend | output | 1 | Any SCSI status pending |
| halt_req | output | 1 | Script engine halt request |
| irq_n | output | 1 | Active-low interrupt request pin |

## Verification
The assertions check on every cycle that:
- no status bit is lost without an acknowledge;
- an event always wins over a same-cycle clear;
- a pending DMA bit always means a halt;
- the pin follows the halt request one cycle later, and never goes low when the previous cycle had a mask or no halt.

Only the bench scenarios can show the mode-dependent classification of every SCSI bit position, the effect of enables on nonfatal bits, and that a masked interrupt appears once the mask drops.

// File: rtl/ihc_pkg.sv
package ihc_pkg;
  localparam int BIT_FUNC_DONE = 0;
  localparam int BIT_SELECTED  = 1;
  localparam int BIT_RESELECT  = 2;
  localparam int BIT_ATTN      = 3;
  localparam int BIT_GP_TIMER  = 4;
  localparam int BIT_HS_TIMER  = 5;

  // Nonfatal classification of one SCSI bit position for the given mode
  function automatic logic is_nonfatal(int idx, logic tgt);
    case (idx)
      BIT_FUNC_DONE, BIT_SELECTED, BIT_RESELECT,
      BIT_GP_TIMER, BIT_HS_TIMER: is_nonfatal = 1'b1;
      BIT_ATTN:                   is_nonfatal = tgt;
      default:                    is_nonfatal = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ihc_sticky.sv
module ihc_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] ack,
  output logic [W-1:0] stat,
  output logic         any
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~ack) | evt;
  end

  assign stat = stat_q;
  assign any  = |stat_q;

  // R1: a set bit survives unless acknowledged
  assert_no_lost_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat_q) & ~$past(ack) & ~stat_q) == '0));
  // R1: an event always sets its bit, even against an acknowledge
  assert_set_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt) & ~stat_q) == '0));
endmodule

// File: rtl/ihc_classify.sv
module ihc_classify #(
  parameter int DMA_W  = 8,
  parameter int SCSI_W = 16
) (
  input  logic [DMA_W-1:0]  dma_stat,
  input  logic [SCSI_W-1:0] scsi_stat,
  input  logic [SCSI_W-1:0] scsi_en,
  input  logic              target_mode,
  output logic              halt
);
  import ihc_pkg::*;

  logic [SCSI_W-1:0] scsi_fatal;

  for (genvar i = 0; i < SCSI_W; i++) begin : g_cls
    assign scsi_fatal[i] = scsi_stat[i] & (~is_nonfatal(i, target_mode) | scsi_en[i]);
  end

  assign halt = (|dma_stat) | (|scsi_fatal);
endmodule

// File: rtl/ihc_pin.sv
module ihc_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic pin_mask,
  output logic irq_n
);
  logic irq_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n_q <= 1'b1;
    else        irq_n_q <= ~(halt & ~pin_mask);
  end

  assign irq_n = irq_n_q;

  // R7: a mask in the previous cycle keeps the pin inactive
  assert_mask_holds_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pin_mask) |-> irq_n);
  // R10: the pin follows an unmasked halt one cycle later
  assert_pin_follows_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt && !pin_mask) |-> !irq_n);
  // R10: no halt in the previous cycle means the pin is released
  assert_pin_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!halt) |-> irq_n);
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl #(
  parameter int DMA_W  = 8,
  parameter int SCSI_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DMA_W-1:0]  dma_evt,
  input  logic [SCSI_W-1:0] scsi_evt,
  input  logic              target_mode,
  input  logic [SCSI_W-1:0] scsi_en,
  input  logic              pin_mask,
  input  logic [DMA_W-1:0]  dma_ack,
  input  logic [SCSI_W-1:0] scsi_ack,
  output logic [DMA_W-1:0]  dma_stat,
  output logic [SCSI_W-1:0] scsi_stat,
  output logic              dma_pend,
  output logic              scsi_pend,
  output logic              halt_req,
  output logic              irq_n
);
  ihc_sticky #(.W(DMA_W)) u_dma (
    .clk(clk), .rst_n(rst_n), .evt(dma_evt), .ack(dma_ack),
    .stat(dma_stat), .any(dma_pend));

  ihc_sticky #(.W(SCSI_W)) u_scsi (
    .clk(clk), .rst_n(rst_n), .evt(scsi_evt), .ack(scsi_ack),
    .stat(scsi_stat), .any(scsi_pend));

  ihc_classify #(.DMA_W(DMA_W), .SCSI_W(SCSI_W)) u_cls (
    .dma_stat(dma_stat), .scsi_stat(scsi_stat), .scsi_en(scsi_en),
    .target_mode(target_mode), .halt(halt_req));

  ihc_pin u_pin (
    .clk(clk), .rst_n(rst_n), .halt(halt_req), .pin_mask(pin_mask), .irq_n(irq_n));

  // R2: any pending DMA bit demands a halt
  assert_dma_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dma_pend |-> halt_req);
  // R9: nothing is pending, so there is no halt
  assert_idle_no_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_pend && !scsi_pend) |-> !halt_req);
endmodule

// File: tb/irq_halt_ctrl_tb.sv
module irq_halt_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DMA_W  = 8;
  localparam int SCSI_W = 16;

  logic clk = 0, rst_n = 0;
  logic [DMA_W-1:0]  dma_evt = '0, dma_ack = '0;
  logic [SCSI_W-1:0] scsi_evt = '0, scsi_ack = '0, scsi_en = '0;
  logic target_mode = 0, pin_mask = 0;
  logic [DMA_W-1:0]  dma_stat;
  logic [SCSI_W-1:0] scsi_stat;
  logic dma_pend, scsi_pend, halt_req, irq_n;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_halt_ctrl #(.DMA_W(DMA_W), .SCSI_W(SCSI_W)) u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench view of which SCSI positions are nonfatal
  function automatic bit ref_nonfatal(int i, bit tgt);
    return (i <= 5) && (i != 3 || tgt);
  endfunction

  task automatic pulse(logic [DMA_W-1:0] d, logic [SCSI_W-1:0] s);
    dma_evt = d; scsi_evt = s;
    @(negedge clk);
    dma_evt = '0; scsi_evt = '0;
  endtask

  task automatic clear_all();
    dma_ack = '1; scsi_ack = '1;
    @(negedge clk);
    dma_ack = '0; scsi_ack = '0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 dma_stat", dma_stat, 0);
    check("R11 scsi_stat", scsi_stat, 0);
    check("R11 halt", halt_req, 0);
    check("R11 pend", {dma_pend, scsi_pend}, 0);
    check("R11 irq_n", irq_n, 1);
  endtask

  task automatic t_dma();
    pulse(8'h04, '0);
    check("R1 dma set", dma_stat, 8'h04);
    check("R9 dma_pend", dma_pend, 1);
    check("R2 halt", halt_req, 1);
    check("R10 irq not yet", irq_n, 1);
    @(negedge clk);
    check("R10 irq low", irq_n, 0);
    dma_ack = 8'h04; dma_evt = 8'h04;
    @(negedge clk);
    dma_ack = '0; dma_evt = '0;
    check("R1 set wins", dma_stat, 8'h04);
    dma_ack = 8'h04;
    @(negedge clk);
    dma_ack = '0;
    check("R1 cleared", dma_stat, 0);
    check("R10 halt drop", halt_req, 0);
    check("R10 irq still low", irq_n, 0);
    @(negedge clk);
    check("R10 irq release", irq_n, 1);
  endtask

  task automatic t_classify(bit tgt);
    target_mode = tgt; scsi_en = '0;
    for (int i = 0; i < SCSI_W; i++) begin
      pulse('0, SCSI_W'(1) << i);
      check("R1 scsi latch", scsi_stat, SCSI_W'(1) << i);
      check("R9 scsi_pend", scsi_pend, 1);
      if (i == 3) check(tgt ? "R4 attn tgt" : "R4 attn init", halt_req, !ref_nonfatal(i, tgt));
      else if (i > 5) check("R5 fatal", halt_req, 1);
      else check("R3 nonfatal", halt_req, 0);
      @(negedge clk);
      check("R3 pin", irq_n, ref_nonfatal(i, tgt));
      clear_all();
    end
  endtask

  task automatic t_enable();
    target_mode = 0; scsi_en = 16'h0001;
    pulse('0, 16'h0001);
    check("R6 enabled halts", halt_req, 1);
    @(negedge clk);
    check("R6 enabled pin", irq_n, 0);
    scsi_en = '0;
    clear_all();
  endtask

  task automatic t_mask();
    pin_mask = 1;
    pulse(8'h80, '0);
    @(negedge clk); @(negedge clk);
    check("R7 masked pin", irq_n, 1);
    check("R7 status kept", dma_stat, 8'h80);
    check("R7 halt kept", halt_req, 1);
    pin_mask = 0;
    @(negedge clk);
    check("R8 unmask asserts", irq_n, 0);
    clear_all();
    check("R10 idle pin", irq_n, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_dma();
    t_classify(0);
    t_classify(1);
    t_enable();
    t_mask();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule